// File: doc/BRIEF.md
# Byte-Slot Disk Control Sequencer

This block paces the control strobes of a disk read/write channel one serial-stream byte at a time. A start pulse selects one of four operations: read sector, write sector, read header or format track. The operation picks a 128-slot region of a control table. On every byte strobe the sequencer presents the control word of the current slot on its outputs and moves on to the next slot. Each word sets seven strobes: the source select (buffer RAM or serial register/CRC), the bus direction, read, compare, mark, prom enable and latch.

Each region has three 32-slot blocks: before the data field, the data field and after the data field. In the read and header operations and in write sector, the sequencer parks on a sync-wait slot until the mark detector reports a sync. The data-field block repeats once for each 32 bytes of the sector, and the count comes from a 4-bit size input. When the region's final slot has been presented, a one-cycle done pulse is raised and the sequencer goes idle. The table is computed from a function in the package and is therefore synthesised as a ROM.

Top module: `disk_byte_sequencer`

## Requirements
- R1: After reset every strobe output and done are 0.
- R2: A start pulse captures op (0 read sector, 1 write sector, 2 read header, 3 format track; region base op*0x80) and size, and sets the slot pointer to 0. The first byte strobe after start presents slot 0. A start during a run restarts the run in the new region. A strobe in the same cycle as start is not acted on.
- R3: Outputs change only on a cycle with byte_strobe high; with no strobe they hold. A strobe while idle drives all seven strobes to 0.
- R4: Slots 0 and 1 (alignment): rd_en=0, cmp_en=0, mark_en=0, src_sr=0, prom_en=1, latch_en=1, and bus_drv=1 only for the write-type ops 1 and 3.
- R5: In ops 0, 1 and 2, slot 2 is a sync wait with rd_en=1 and every other strobe 0. It is presented again on each strobe until a strobe with sync_det high, and the next strobe then presents slot 3. In op 3, slot 2 is an ordinary before-field slot, and sync_det has no effect in any other slot.
- R6: Slots 3 to 31 (op 3 also slot 2), where wr means op 1 or 3: src_sr=1 only at slots 7 and 8; rd_en=!wr; bus_drv=wr; cmp_en=1 only for non-wr ops at slots up to 8; mark_en=1 only for wr ops at slot 3; prom_en=latch_en=1.
- R7: Slots 32 to 63 (data field): src_sr=!wr, rd_en=!wr, bus_drv=wr, cmp_en=mark_en=0, prom_en=latch_en=1.
- R8: The data-field block is presented size times, or once when size is 0. After the last pass, slot 64 follows slot 63.
- R9: Slots 64 to 95 (after data field): src_sr=1 only at slots 64 and 65 (CRC); rd_en=!wr; bus_drv=wr; cmp_en=mark_en=0; prom_en=latch_en=1.
- R10: done is high for exactly one cycle, alongside the outputs of slot 95. The sequencer is then idle until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle run start |
| op | input | 2 | Operation / region select |
| size | input | 4 | Data-field passes (bytes per sector / 32) |
| byte_strobe | input | 1 | One-cycle pulse per disk byte |
| sync_det | input | 1 | Sync mark detected |
| src_sr | output | 1 | 1 = serial register/CRC source, 0 = RAM |
| bus_drv | output | 1 | Bus direction, 1 = toward the disk |
| rd_en | output | 1 | Read strobe |
| cmp_en | output | 1 | Compare strobe |
| mark_en | output | 1 | Mark strobe |
| prom_en | output | 1 | Prom enable |
| latch_en | output | 1 | Latch strobe |
| done | output | 1 | One-cycle end-of-region pulse |

## Verification
The bench holds the sync-wait slot for several strobes. A pointer that moves too early would shift every later word and end the run short. A size of 0 is run beside sizes 1, 2 and 4: a loop counter that wraps would circle the data field sixteen times, and one off by one would add or drop a whole 32-strobe pass. sync_det is toggled outside the wait slot and in the format region, where a sequencer that listens there would not stall. A mid-run restart into another region and idle clocks without strobes show whether outputs ever move off the byte clock.

// File: rtl/disk_seq_pkg.sv
package disk_seq_pkg;

    localparam int OP_W        = 2;
    localparam int SIZE_W      = 4;
    localparam int SLOT_W      = 7;
    localparam int ADDR_W      = OP_W + SLOT_W;
    localparam int BLK         = 32;
    localparam int SYNC_SLOT   = 2;
    localparam int DATA_FIRST  = BLK;
    localparam int DATA_LAST   = 2 * BLK - 1;
    localparam int REGION_LAST = 3 * BLK - 1;
    localparam int HDR_CRC_A   = 7;
    localparam int HDR_CRC_B   = 8;
    localparam int TAIL_CRC_B  = 2 * BLK + 1;

    typedef enum logic [OP_W-1:0] {
        OP_RD_SECT = 2'd0,
        OP_WR_SECT = 2'd1,
        OP_RD_HDR  = 2'd2,
        OP_FORMAT  = 2'd3
    } op_e;

    typedef struct packed {
        logic src_sr;
        logic bus_drv;
        logic rd;
        logic cmp;
        logic mark;
        logic prom;
        logic latch;
    } strobes_t;

    typedef struct packed {
        strobes_t s;
        logic     wait_sync;
        logic     loop_end;
        logic     last;
    } word_t;

    function automatic word_t build_word(input op_e op, input logic [SLOT_W-1:0] slot);
        word_t w;
        logic  wr;
        int    n;
        n  = int'(slot);
        wr = (op == OP_WR_SECT) || (op == OP_FORMAT);
        w  = '0;
        if (n < SYNC_SLOT) begin
            w.s.prom    = 1'b1;
            w.s.latch   = 1'b1;
            w.s.bus_drv = wr;
        end else if (n == SYNC_SLOT && op != OP_FORMAT) begin
            w.s.rd      = 1'b1;
            w.wait_sync = 1'b1;
        end else if (n < DATA_FIRST) begin
            w.s.src_sr  = (n == HDR_CRC_A) || (n == HDR_CRC_B);
            w.s.rd      = !wr;
            w.s.bus_drv = wr;
            w.s.cmp     = !wr && (n <= HDR_CRC_B);
            w.s.mark    = wr && (n == SYNC_SLOT + 1);
            w.s.prom    = 1'b1;
            w.s.latch   = 1'b1;
        end else if (n <= DATA_LAST) begin
            w.s.src_sr  = !wr;
            w.s.rd      = !wr;
            w.s.bus_drv = wr;
            w.s.prom    = 1'b1;
            w.s.latch   = 1'b1;
            w.loop_end  = (n == DATA_LAST);
        end else if (n <= REGION_LAST) begin
            w.s.src_sr  = (n <= TAIL_CRC_B);
            w.s.rd      = !wr;
            w.s.bus_drv = wr;
            w.s.prom    = 1'b1;
            w.s.latch   = 1'b1;
            w.last      = (n == REGION_LAST);
        end
        return w;
    endfunction

endpackage

// File: rtl/disk_seq_rom.sv
module disk_seq_rom
    import disk_seq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output word_t             word
);
    always_comb begin
        word = build_word(op_e'(addr[ADDR_W-1 -: OP_W]), addr[SLOT_W-1:0]);
    end
endmodule

// File: rtl/disk_seq_loop.sv
module disk_seq_loop
    import disk_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SIZE_W-1:0] size,
    input  logic              dec,
    output logic              last_pass
);
    logic [SIZE_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= SIZE_W'(1);
        end else if (load) begin
            cnt <= (size == '0) ? SIZE_W'(1) : size;
        end else if (dec && cnt > SIZE_W'(1)) begin
            cnt <= cnt - SIZE_W'(1);
        end
    end

    assign last_pass = (cnt == SIZE_W'(1));

    // R8: the pass count never reaches zero, so a size of 0 cannot wrap
    assert_cnt_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
        cnt != '0);

    // R8: a load of a nonzero size is taken as the pass count
    assert_load_size_R8: assert property (@(posedge clk) disable iff (rst)
        (load && size != '0) |=> (cnt == $past(size)));
endmodule

// File: rtl/disk_byte_sequencer.sv
module disk_byte_sequencer
    import disk_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OP_W-1:0]   op,
    input  logic [SIZE_W-1:0] size,
    input  logic              byte_strobe,
    input  logic              sync_det,
    output logic              src_sr,
    output logic              bus_drv,
    output logic              rd_en,
    output logic              cmp_en,
    output logic              mark_en,
    output logic              prom_en,
    output logic              latch_en,
    output logic              done
);
    logic [SLOT_W-1:0] ptr;
    logic              active;
    op_e               op_q;
    word_t             w;
    strobes_t          outs;
    logic              step;
    logic              last_pass;

    disk_seq_rom u_rom (
        .addr ({op_q, ptr}),
        .word (w)
    );

    assign step = byte_strobe && active && !start;

    disk_seq_loop u_loop (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .size      (size),
        .dec       (step && w.loop_end),
        .last_pass (last_pass)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr    <= '0;
            active <= 1'b0;
            op_q   <= OP_RD_SECT;
            outs   <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                ptr    <= '0;
                active <= 1'b1;
                op_q   <= op_e'(op);
            end else if (byte_strobe) begin
                if (active) begin
                    outs <= w.s;
                    if (w.last) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else if (w.wait_sync && !sync_det) begin
                        ptr <= ptr;
                    end else if (w.loop_end && !last_pass) begin
                        ptr <= SLOT_W'(DATA_FIRST);
                    end else begin
                        ptr <= ptr + 1'b1;
                    end
                end else begin
                    outs <= '0;
                end
            end
        end
    end

    assign src_sr   = outs.src_sr;
    assign bus_drv  = outs.bus_drv;
    assign rd_en    = outs.rd;
    assign cmp_en   = outs.cmp;
    assign mark_en  = outs.mark;
    assign prom_en  = outs.prom;
    assign latch_en = outs.latch;

    // R3: no byte strobe, no output movement
    assert_hold_no_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        !byte_strobe |=> $stable(outs));

    // R5: a wait word only ever comes from the sync slot
    assert_wait_at_sync_R5: assert property (@(posedge clk) disable iff (rst)
        (active && w.wait_sync) |-> (ptr == SLOT_W'(SYNC_SLOT)));

    // R5: the sync-wait word shows read alone
    assert_sync_flags_R5: assert property (@(posedge clk) disable iff (rst)
        (step && w.wait_sync) |=> (outs.rd && !outs.cmp && !outs.mark && !outs.prom && !outs.latch));

    // R10: done is a single-cycle pulse and leaves the sequencer idle
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !active);
endmodule

// File: tb/disk_byte_sequencer_test.sv
module disk_byte_sequencer_test;
    localparam time CLK_P = 20ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] op = '0;
    logic [3:0] size = '0;
    logic       byte_strobe = 1'b0;
    logic       sync_det = 1'b0;
    logic       src_sr, bus_drv, rd_en, cmp_en, mark_en, prom_en, latch_en, done;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_P/2) clk = ~clk;

    disk_byte_sequencer uut (
        .clk(clk), .rst(rst), .start(start), .op(op), .size(size),
        .byte_strobe(byte_strobe), .sync_det(sync_det),
        .src_sr(src_sr), .bus_drv(bus_drv), .rd_en(rd_en), .cmp_en(cmp_en),
        .mark_en(mark_en), .prom_en(prom_en), .latch_en(latch_en), .done(done)
    );

    function automatic logic [6:0] flags_now();
        return {src_sr, bus_drv, rd_en, cmp_en, mark_en, prom_en, latch_en};
    endfunction

    // expected {src,bus,rd,cmp,mark,prom,latch} from R4..R9
    function automatic logic [6:0] exp_flags(int o, int s);
        logic wr;
        wr = (o == 1) || (o == 3);
        if (s < 2)                return {1'b0, wr, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
        if (s == 2 && o != 3)     return 7'b0010000;
        if (s < 32)               return {(s == 7 || s == 8), wr, !wr, (!wr && s <= 8), (wr && s == 3), 1'b1, 1'b1};
        if (s < 64)               return {!wr, wr, !wr, 1'b0, 1'b0, 1'b1, 1'b1};
        return {(s <= 65), wr, !wr, 1'b0, 1'b0, 1'b1, 1'b1};
    endfunction

    function automatic string req_of(int o, int s);
        if (s < 2)            return "R4";
        if (s == 2 && o != 3) return "R5";
        if (s < 32)           return "R6";
        if (s < 64)           return "R7";
        return "R9";
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(int o, int sz);
        @(negedge clk);
        op = 2'(o); size = 4'(sz); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic strobe(bit s);
        @(negedge clk);
        byte_strobe = 1'b1; sync_det = s;
        @(negedge clk);
        byte_strobe = 1'b0; sync_det = 1'b0;
    endtask

    // runs one full region; sync_delay strobes without sync at the wait slot
    task automatic run_op(int o, int sz, int sync_delay);
        int ptr = 0;
        int held = 0;
        int count = 0;
        int passes = (sz == 0) ? 1 : sz;
        int left = passes;
        bit s;
        pulse_start(o, sz);
        while (count < 2000) begin
            if (ptr == 2 && o != 3) s = (held == sync_delay);
            else                    s = count[0];
            strobe(s);
            count++;
            chk(flags_now() == exp_flags(o, ptr), req_of(o, ptr),
                $sformatf("op%0d slot%0d flags", o, ptr), flags_now(), exp_flags(o, ptr));
            chk(done == (ptr == 95), "R10", $sformatf("op%0d slot%0d done", o, ptr), done, ptr == 95);
            if (ptr == 95) break;
            if (ptr == 2 && o != 3 && !s) held++;
            else if (ptr == 63 && left > 1) begin left--; ptr = 32; end
            else ptr++;
        end
        chk(count == 64 + 32 * passes + ((o != 3) ? sync_delay : 0), "R8",
            $sformatf("op%0d size%0d strobes to done", o, sz), count,
            64 + 32 * passes + ((o != 3) ? sync_delay : 0));
        @(negedge clk);
        chk(done == 1'b0, "R10", "done after one cycle", done, 0);
        strobe(1'b1);
        chk(flags_now() == 7'b0 && done == 1'b0, "R3", "idle strobe outputs", flags_now(), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(flags_now() == 7'b0, "R1", "strobes after reset", flags_now(), 0);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        rst = 1'b0;
    endtask

    task automatic t_no_strobe();
        logic [6:0] snap;
        pulse_start(1, 2);
        chk(flags_now() == 7'b0, "R2", "start alone moves no output", flags_now(), 0);
        strobe(1'b0);
        strobe(1'b0);
        snap = flags_now();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            sync_det = i[0];
            chk(flags_now() == snap, "R3", "outputs hold without strobe", flags_now(), snap);
        end
        sync_det = 1'b0;
    endtask

    task automatic t_restart();
        pulse_start(0, 3);
        repeat (5) strobe(1'b1);
        run_op(3, 1, 0);   // R2: first word must be op3 slot 0 (bus_drv=1)
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        run_op(0, 2, 3);
        run_op(1, 1, 0);
        run_op(2, 0, 1);
        run_op(3, 4, 0);
        t_no_strobe();
        t_restart();
        run_op(0, 15, 2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule